// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is a clocked model of a read-only memory whose read port is set to one of two widths by a strap input. In word organization, each location is 16 bits wide and the whole data bus carries the word. In byte organization, the memory appears as twice as many 8-bit locations. One extra input, the shared pin, then serves as the address bit below `addr[0]`. The same pin carries data bit 15 in word organization. In byte organization the upper data lane is never driven.

Read access is gated by an active-low chip enable and an active-low output enable. Each of three paths has its own latency measured in clock cycles: the address (including the shared pin in byte organization), the chip enable and the output enable. Data is flagged valid and driven only after the slowest of these three paths has settled. Separate lane-enable outputs tell the surrounding logic when each half of the bus may be driven. The memory contents are a fixed arithmetic function of the word address, so the block needs no initialization file.

Top module: `brw_rom_port`

## Requirements
- R1: Word organization (`word_mode`=1), after settling, gives the following on the same output sample:
  - `valid`=1, `lo_en`=1 and `hi_en`=1.
  - `dq` = ROM(`addr`), where ROM(w) = ((w × 0x9E37) mod 2^16) XOR 0x5AC3.
- R2: Byte organization (`word_mode`=0) forms the byte address {`addr`, `lsb_in`}.
  - `lsb_in`=0 returns bits 7:0 of ROM(`addr`), and `lsb_in`=1 returns bits 15:8, in both cases on `dq[7:0]`.
  - `dq[15:8]` is 0 and `hi_en` is 0 at all times.
- R3: While `ce_n` is 1, the next output sample has `valid`, `lo_en` and `hi_en` all 0 and `dq` 0, whatever the other inputs are.
- R4: While `ce_n` is 0 and `oe_n` is 1, the next output sample has `valid`, `lo_en` and `hi_en` all 0 and `dq` 0.
- R5: Address latency is counted in rising edges that sample the new, held address key.
  - The address key is `addr`, plus `lsb_in` in byte organization.
  - With `ce_n` and `oe_n` settled low, `valid` stays 0 through the first LAT−1 such edges and is 1 after the LAT-th.
- R6: After `ce_n` falls with the address and `oe_n` settled, `valid` stays 0 through LAT−1 rising edges and rises with the LAT-th.
- R7: After `oe_n` falls with the address and `ce_n` settled, `valid` stays 0 through LAT/2−1 rising edges and rises with the (LAT/2)-th.
- R8: When the paths restart at different times, `valid` rises only when the path that restarted last has completed its own latency.
- R9: In word organization, changes on `lsb_in` do not restart any latency and do not change `dq`.
- R10: While `rst` is 1, all outputs are 0 from the first rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | Strap input: 1 selects word organization, 0 selects byte organization; held constant outside reset |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lsb_in | input | 1 | Shared pin sampled as the byte-select address bit in byte organization |
| dq | output | 16 | Data; bit 15 is the shared pin's output value in word organization |
| lo_en | output | 1 | Drive enable for `dq[7:0]` |
| hi_en | output | 1 | Drive enable for `dq[15:8]` and the shared pin |
| valid | output | 1 | Data valid |

## Verification
The hardest case to reach is the one where the three latency paths restart at different cycles, because only then does the "latest path wins" rule matter. The bench drives that case with negedge-timed stimulus. It lowers `ce_n` first and changes the address two edges later. In a second case it holds `oe_n` high until the address has settled and then releases it. In both cases it samples `valid` exactly one edge before and at the expected rising edge. Both organizations are swept over every location. Each move to a new location is also checked one edge early, which confirms that the shared pin restarts the address path in byte organization and is ignored in word organization.

// File: rtl/brw_pkg.sv
package brw_pkg;
  localparam int DW = 16;
  localparam int BW = 8;

  typedef logic [DW-1:0] word_t;
  typedef logic [BW-1:0] byte_t;

  // Fixed contents: multiplicative hash of the word index, folded with a constant
  function automatic word_t rom_word(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'h0000_9E37;
    return prod[DW-1:0] ^ 16'h5AC3;
  endfunction
endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic settled
);
  localparam int CW = $clog2(CYC) + 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (restart)        cnt_nxt = LOAD;
    else if (cnt == '0) cnt_nxt = '0;
    else                cnt_nxt = cnt - 1'b1;
  end

  assign settled = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= LOAD;
    else     cnt <= cnt_nxt;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);
endmodule

// File: rtl/rom_array.sv
module rom_array
  import brw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int DEPTH = 1 << AW;

  word_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(i);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/brw_rom_port.sv
module brw_rom_port
  import brw_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          lsb_in,
  output logic [15:0]   dq,
  output logic          lo_en,
  output logic          hi_en,
  output logic          valid
);
  localparam int OE_CYC = (LAT / 2 < 1) ? 1 : LAT / 2;
  localparam int KW     = AW + 1;
  localparam int NPATH  = 3;

  logic [KW-1:0]    key, key_q;
  logic             ce_q, oe_q;
  logic [NPATH-1:0] restart, settled;
  word_t            word, dq_nxt;
  logic             valid_nxt;

  assign key        = {addr, (word_mode ? 1'b0 : lsb_in)};
  assign restart[0] = (key != key_q);
  assign restart[1] = ce_n | ce_q;
  assign restart[2] = oe_n | oe_q;

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    localparam int CYC = (i == 2) ? OE_CYC : LAT;
    lat_timer #(.CYC(CYC)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .restart (restart[i]),
      .settled (settled[i])
    );
  end

  rom_array #(.AW(AW)) u_rom (
    .raddr (addr),
    .rdata (word)
  );

  assign valid_nxt = (&settled) & ~ce_n & ~oe_n;

  always_comb begin
    if (!valid_nxt)     dq_nxt = '0;
    else if (word_mode) dq_nxt = word;
    else                dq_nxt = {8'h00, (lsb_in ? word[15:8] : word[7:0])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      ce_q  <= 1'b1;
      oe_q  <= 1'b1;
      dq    <= '0;
      lo_en <= 1'b0;
      hi_en <= 1'b0;
      valid <= 1'b0;
    end else begin
      key_q <= key;
      ce_q  <= ce_n;
      oe_q  <= oe_n;
      dq    <= dq_nxt;
      lo_en <= valid_nxt;
      hi_en <= valid_nxt & word_mode;
      valid <= valid_nxt;
    end
  end

  // R3
  ce_off_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!valid && !lo_en && !hi_en && dq == '0));

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n) |=> (!valid && !lo_en && !hi_en));

  // R2
  byte_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !word_mode |=> (!hi_en && dq[15:8] == 8'h00));

  // R5
  addr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ((LAT > 1) && (key != key_q)) |=> !valid);

  // R1
  lane_valid_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> lo_en);

  // R2 strap held outside reset
  mode_strap_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(word_mode));
endmodule

// File: tb/sim_brw_rom_port.sv
module sim_brw_rom_port;
  localparam int AW  = 4;
  localparam int LAT = 4;
  localparam int OEL = LAT / 2;
  localparam int NW  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst, word_mode, ce_n, oe_n, lsb_in;
  logic [AW-1:0] addr;
  logic [15:0] dq;
  logic        lo_en, hi_en, valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  brw_rom_port #(.AW(AW), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .word_mode(word_mode), .addr(addr),
    .ce_n(ce_n), .oe_n(oe_n), .lsb_in(lsb_in),
    .dq(dq), .lo_en(lo_en), .hi_en(hi_en), .valid(valid)
  );

  function automatic logic [15:0] exp_word(input int a);
    int unsigned p;
    p = (a * 40503) & 32'hFFFF;
    return 16'(p) ^ 16'h5AC3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wait n rising edges, land on following negedge
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic outs(input string req, input logic [15:0] d, input logic lo, input logic hi, input logic v);
    check(req, {13'b0, v, hi, lo, d}, {13'b0, v, hi, lo, 16'h0} | {16'h0, d});
  endtask

  initial begin
    rst = 1; word_mode = 1; ce_n = 1; oe_n = 1; lsb_in = 0; addr = '0;
    @(negedge clk);
    edges(2);
    outs("R10 reset outputs", dq, lo_en, hi_en, valid);
    check("R10 reset", {dq, lo_en, hi_en, valid}, 19'h0);
    rst = 0;

    // R3: chip disabled, output enabled
    oe_n = 0;
    edges(LAT + 2);
    check("R3 ce high word", {dq, lo_en, hi_en, valid}, 19'h0);

    // R6: chip enable falls, address and oe settled
    ce_n = 0;
    edges(LAT - 1);
    check("R6 before", valid, 0);
    edges(1);
    check("R6 at latency", valid, 1);
    check("R6 data", dq, exp_word(0));

    // R1/R5: word sweep
    for (int k = 0; k < NW; k++) begin
      int a;
      a = (k + 1) % NW;
      addr = AW'(a);
      edges(LAT - 1);
      check("R5 word early", valid, 0);
      edges(1);
      check("R1 word data", dq, exp_word(a));
      check("R1 word lanes", {lo_en, hi_en, valid}, 3'b111);
    end

    // R9: shared pin ignored in word mode
    addr = 4'd5;
    edges(LAT);
    lsb_in = 1;
    edges(1);
    check("R9 no restart", valid, 1);
    check("R9 data", dq, exp_word(5));
    lsb_in = 0;
    edges(LAT);
    check("R9 data later", dq, exp_word(5));

    // R4 then R7
    oe_n = 1;
    edges(1);
    check("R4 oe high", {dq, lo_en, hi_en, valid}, 19'h0);
    edges(LAT);
    check("R4 oe high held", valid, 0);
    oe_n = 0;
    edges(OEL - 1);
    check("R7 before", valid, 0);
    edges(1);
    check("R7 at latency", valid, 1);
    check("R7 data", dq, exp_word(5));

    // R8: ce restarts first, address two edges later
    ce_n = 1;
    edges(2);
    ce_n = 0;
    edges(2);
    addr = 4'd9;
    edges(LAT - 1);
    check("R8 addr last early", valid, 0);
    edges(1);
    check("R8 addr last", valid, 1);
    check("R8 data", dq, exp_word(9));

    // R8: oe released after address settled
    oe_n = 1;
    addr = 4'd11;
    edges(LAT + 1);
    oe_n = 0;
    edges(OEL - 1);
    check("R8 oe last early", valid, 0);
    edges(1);
    check("R8 oe last", valid, 1);
    check("R8 oe data", dq, exp_word(11));

    // byte organization
    rst = 1;
    @(negedge clk);
    word_mode = 0;
    addr = '0;
    lsb_in = 0;
    edges(2);
    check("R10 reset byte", {dq, lo_en, hi_en, valid}, 19'h0);
    rst = 0;
    edges(LAT);
    for (int k = 0; k < 2 * NW; k++) begin
      int b;
      logic [15:0] w;
      b = (k + 1) % (2 * NW);
      addr = AW'(b >> 1);
      lsb_in = b[0];
      w = exp_word(b >> 1);
      edges(LAT - 1);
      check("R5 byte early", valid, 0);
      edges(1);
      check("R2 byte data", dq, {8'h00, (b[0] ? w[15:8] : w[7:0])});
      check("R2 byte lanes", {lo_en, hi_en, valid}, 3'b101);
    end

    ce_n = 1;
    edges(1);
    check("R3 ce high byte", {dq, lo_en, hi_en, valid}, 19'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule